// File: doc/BRIEF.md
# Bus Snoop Cache Flush Trigger

This block sits beside a processor that has an internal write-through cache and watches the processor's bus. At the start of every bus cycle it classifies the cycle from three cycle-definition lines. An I/O read or an interrupt acknowledge is a likely point where the processor picks up data that another agent has just placed in memory, so either one can raise an invalidate request on an active-low flush line. A second trigger is the moment another bus master is granted the bus, seen as the rising edge of the hold acknowledge line. Each trigger has its own enable input.

Because the cache is write-through, a flush here only invalidates. No data is written back. The flush line is held low for a programmable number of clocks so that it meets the cache's minimum pulse width. A trigger that arrives while the pulse is running restarts the count.

The control is a two-state machine. `ST_IDLE` leaves the flush line high. `ST_PULSE` drives it low while a down-counter runs. The transitions are:
- START (`ST_IDLE` to `ST_PULSE`) on any trigger.
- RESTART (`ST_PULSE` to `ST_PULSE`, counter reloaded) on a trigger during the pulse.
- COUNT (`ST_PULSE` to `ST_PULSE`, counter decremented) while the counter is non-zero.
- DONE (`ST_PULSE` to `ST_IDLE`) when the counter reaches zero and no trigger is present.

A hold-based trigger cannot tell a refresh hold from a real transfer. Every hold episode therefore costs one flush.

Top module: `snoop_flush_trigger`

## Requirements
- R1: While `rst_n` is low, and after reset until the first trigger, `flush_n` is high. The state machine is in `ST_IDLE`.
- R2: On a clock edge where `ads_n` is 0 and the cycle code {`cyc_mem`,`cyc_data`,`cyc_wr`} is 3'b010 (an I/O read) with `en_io_rd` set, `flush_n` goes low from that edge. It stays low for `pulse_len`+1 clocks.
- R3: On a clock edge where `ads_n` is 0 and the cycle code is 3'b000 (an interrupt acknowledge) with `en_inta` set, `flush_n` goes low from that edge. It stays low for `pulse_len`+1 clocks.
- R4: The cycle code is sampled only on an edge where `ads_n` is 0. With `ads_n` at 1, an I/O read or interrupt acknowledge code causes no flush.
- R5: These cycle codes never cause a flush:
  - any memory cycle (`cyc_mem`=1);
  - I/O writes (3'b011);
  - special cycles (3'b001).
- R6: An I/O read with `en_io_rd` at 0 causes no flush. An interrupt acknowledge with `en_inta` at 0 causes no flush.
- R7: With `en_hold` set, a 0-to-1 change of `hold_ack` seen at a clock edge starts one pulse. A hold held high for many clocks produces only that one pulse.
- R8: `en_hold` is checked only at the rising edge of `hold_ack`. Setting it during an ongoing hold causes no flush. A rising edge with `en_hold` at 0 causes no flush.
- R9: A trigger at any edge while `flush_n` is low reloads the count. `flush_n` then stays low for `pulse_len`+1 clocks counted from that edge.
- R10: `pulse_len` of 0 gives a one-clock pulse. `pulse_len` of 15 gives a sixteen-clock pulse. Without a new trigger, `flush_n` is never low for more than 16 consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, low on the first clock of a bus cycle |
| cyc_mem | input | 1 | Cycle definition: 1 memory, 0 I/O or control |
| cyc_data | input | 1 | Cycle definition: 1 data, 0 control |
| cyc_wr | input | 1 | Cycle definition: 1 write, 0 read |
| hold_ack | input | 1 | Hold acknowledge, high while another master owns the bus |
| en_io_rd | input | 1 | Enable flush on I/O reads |
| en_inta | input | 1 | Enable flush on interrupt acknowledges |
| en_hold | input | 1 | Enable flush on bus handover |
| pulse_len | input | 4 | Flush pulse length minus one, in clocks |
| flush_n | output | 1 | Active-low cache invalidate request |

## Verification
The assertions are checked on every cycle. They cover five properties:
- `flush_n` is high in reset.
- A qualified I/O read or interrupt acknowledge is followed by a low `flush_n`.
- A rising hold edge with the enable set is followed by a low `flush_n`.
- A high `flush_n` stays high when no trigger is present.
- A low run never exceeds sixteen clocks after the last trigger.

Exact pulse lengths for several `pulse_len` values, the restart of the count, and the single pulse over a long hold come only from the bench's reference model. The same holds for an enable that changes during a hold and for strobe-less cycles.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } flush_state_e;

    typedef enum logic [2:0] {
        CK_MEMORY,
        CK_IO_READ,
        CK_IO_WRITE,
        CK_INT_ACK,
        CK_SPECIAL
    } cycle_kind_e;

    // Code order is {mem, data, wr}
    function automatic cycle_kind_e classify(input logic mem, input logic data, input logic wr);
        cycle_kind_e kind;
        if (mem) begin
            kind = CK_MEMORY;
        end else begin
            unique case ({data, wr})
                2'b10:   kind = CK_IO_READ;
                2'b11:   kind = CK_IO_WRITE;
                2'b00:   kind = CK_INT_ACK;
                default: kind = CK_SPECIAL;
            endcase
        end
        return kind;
    endfunction

endpackage

// File: rtl/sft_cycle_decode.sv
module sft_cycle_decode
    import sft_pkg::*;
(
    input  logic ads_n,
    input  logic cyc_mem,
    input  logic cyc_data,
    input  logic cyc_wr,
    input  logic en_io_rd,
    input  logic en_inta,
    output logic cyc_trig
);

    cycle_kind_e kind;

    always_comb begin
        kind     = classify(cyc_mem, cyc_data, cyc_wr);
        cyc_trig = 1'b0;
        if (!ads_n) begin
            unique case (kind)
                CK_IO_READ: cyc_trig = en_io_rd;
                CK_INT_ACK: cyc_trig = en_inta;
                default:    cyc_trig = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sft_hold_edge.sv
module sft_hold_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_ack,
    input  logic en_hold,
    output logic hold_prev,
    output logic hold_trig
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_prev <= 1'b0;
        end else begin
            hold_prev <= hold_ack;
        end
    end

    assign hold_trig = en_hold & hold_ack & ~hold_prev;

endmodule

// File: rtl/sft_pulse_fsm.sv
module sft_pulse_fsm
    import sft_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] load_val,
    output logic             flush_n
);

    flush_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin          // START
                    state_d = ST_PULSE;
                    cnt_d   = load_val;
                end
            end
            ST_PULSE: begin
                if (trig) begin          // RESTART
                    cnt_d = load_val;
                end else if (cnt_q != '0) begin  // COUNT
                    cnt_d = cnt_q - 1'b1;
                end else begin           // DONE
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PULSE: flush_n = 1'b0;
            default:  flush_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/snoop_flush_trigger.sv
module snoop_flush_trigger #(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ads_n,
    input  logic             cyc_mem,
    input  logic             cyc_data,
    input  logic             cyc_wr,
    input  logic             hold_ack,
    input  logic             en_io_rd,
    input  logic             en_inta,
    input  logic             en_hold,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             flush_n
);

    logic cyc_trig;
    logic hold_trig;
    logic hold_prev;
    logic any_trig;

    sft_cycle_decode u_decode (
        .ads_n    (ads_n),
        .cyc_mem  (cyc_mem),
        .cyc_data (cyc_data),
        .cyc_wr   (cyc_wr),
        .en_io_rd (en_io_rd),
        .en_inta  (en_inta),
        .cyc_trig (cyc_trig)
    );

    sft_hold_edge u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_ack  (hold_ack),
        .en_hold   (en_hold),
        .hold_prev (hold_prev),
        .hold_trig (hold_trig)
    );

    assign any_trig = cyc_trig | hold_trig;

    sft_pulse_fsm #(.CNT_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (any_trig),
        .load_val (pulse_len),
        .flush_n  (flush_n)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
    parameter int unsigned LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ads_n,
    input logic             cyc_mem,
    input logic             cyc_data,
    input logic             cyc_wr,
    input logic             hold_ack,
    input logic             hold_prev,
    input logic             en_io_rd,
    input logic             en_inta,
    input logic             en_hold,
    input logic [LEN_W-1:0] pulse_len,
    input logic             flush_n
);

    localparam int unsigned MAX_LOW = 1 << LEN_W;

    logic io_hit, inta_hit, hold_hit, any_hit;
    int unsigned low_run;

    assign io_hit   = !ads_n && !cyc_mem && cyc_data && !cyc_wr && en_io_rd;
    assign inta_hit = !ads_n && !cyc_mem && !cyc_data && !cyc_wr && en_inta;
    assign hold_hit = en_hold && hold_ack && !hold_prev;
    assign any_hit  = io_hit || inta_hit || hold_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (any_hit) begin
            low_run <= 0;
        end else if (!flush_n) begin
            low_run <= low_run + 1;
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_high_chk: assert (flush_n);
        end
    end

    // R2
    io_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |=> !flush_n);

    // R3
    inta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_hit |=> !flush_n);

    // R7
    hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_hit |=> !flush_n);

    // R4, R5, R6
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_n && !any_hit) |=> flush_n);

    // R10
    max_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_n |-> (low_run < MAX_LOW));

endmodule

bind snoop_flush_trigger sft_checker #(.LEN_W(LEN_W)) u_sft_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads_n     (ads_n),
    .cyc_mem   (cyc_mem),
    .cyc_data  (cyc_data),
    .cyc_wr    (cyc_wr),
    .hold_ack  (hold_ack),
    .hold_prev (hold_prev),
    .en_io_rd  (en_io_rd),
    .en_inta   (en_inta),
    .en_hold   (en_hold),
    .pulse_len (pulse_len),
    .flush_n   (flush_n)
);

// File: tb/snoop_flush_trigger_bench.sv
module snoop_flush_trigger_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ads_n = 1'b1;
    logic       cyc_mem = 1'b1;
    logic       cyc_data = 1'b1;
    logic       cyc_wr = 1'b0;
    logic       hold_ack = 1'b0;
    logic       en_io_rd = 1'b0;
    logic       en_inta = 1'b0;
    logic       en_hold = 1'b0;
    logic [3:0] pulse_len = 4'd0;
    logic       flush_n;

    int n_checks = 0;
    int n_fail = 0;
    int remaining = 0;
    bit hold_seen = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    snoop_flush_trigger u_snoop_flush_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .ads_n     (ads_n),
        .cyc_mem   (cyc_mem),
        .cyc_data  (cyc_data),
        .cyc_wr    (cyc_wr),
        .hold_ack  (hold_ack),
        .en_io_rd  (en_io_rd),
        .en_inta   (en_inta),
        .en_hold   (en_hold),
        .pulse_len (pulse_len),
        .flush_n   (flush_n)
    );

    // Behavioural reference: a low pulse lasts pulse_len+1 clocks, reloaded by any trigger.
    task automatic model_edge();
        bit fire;
        fire = 1'b0;
        if (!rst_n) begin
            remaining = 0;
            hold_seen = 1'b0;
        end else begin
            if (!ads_n && !cyc_mem && !cyc_wr && cyc_data && en_io_rd) fire = 1'b1;
            if (!ads_n && !cyc_mem && !cyc_wr && !cyc_data && en_inta) fire = 1'b1;
            if (hold_ack && !hold_seen && en_hold) fire = 1'b1;
            hold_seen = hold_ack;
            if (fire) remaining = int'(pulse_len) + 1;
            else if (remaining > 0) remaining = remaining - 1;
        end
    endtask

    task automatic tick(input string tag);
        bit exp_n;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_n = (remaining == 0);
        n_checks++;
        if (flush_n !== exp_n) begin
            n_fail++;
            $display("FAIL %s: flush_n=%b expected %b at %0t", tag, flush_n, exp_n, $time);
        end
    endtask

    task automatic bus(input bit mem, input bit data, input bit wr, input bit strobe, input string tag);
        cyc_mem = mem; cyc_data = data; cyc_wr = wr; ads_n = !strobe;
        tick(tag);
        ads_n = 1'b1; cyc_mem = 1'b1; cyc_data = 1'b1; cyc_wr = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset
        idle(3, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1");

        // R6: triggers disabled
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        bus(1'b0, 1'b0, 1'b0, 1'b1, "R6");
        idle(2, "R6");

        en_io_rd = 1'b1; en_inta = 1'b1;

        // R2: I/O read, several lengths (R10)
        pulse_len = 4'd3;
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R2");
        idle(6, "R2");
        pulse_len = 4'd0;
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R10");
        idle(3, "R10");
        pulse_len = 4'd15;
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R10");
        idle(18, "R10");

        // R3: interrupt acknowledge
        pulse_len = 4'd2;
        bus(1'b0, 1'b0, 1'b0, 1'b1, "R3");
        idle(5, "R3");

        // R4: no strobe
        bus(1'b0, 1'b1, 1'b0, 1'b0, "R4");
        bus(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        idle(2, "R4");

        // R5: non-flushing cycle codes
        for (int c = 0; c < 4; c++) bus(1'b1, c[1], c[0], 1'b1, "R5");
        bus(1'b0, 1'b1, 1'b1, 1'b1, "R5");
        bus(1'b0, 1'b0, 1'b1, 1'b1, "R5");
        idle(2, "R5");

        // R6: individual disables
        en_io_rd = 1'b0;
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        en_io_rd = 1'b1; en_inta = 1'b0;
        bus(1'b0, 1'b0, 1'b0, 1'b1, "R6");
        en_inta = 1'b1;
        idle(2, "R6");

        // R9: restart during pulse, also at final low clock
        pulse_len = 4'd4;
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R9");
        idle(2, "R9");
        bus(1'b0, 1'b0, 1'b0, 1'b1, "R9");
        idle(4, "R9");
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R9");
        idle(7, "R9");

        // R8: hold edge with enable low, then enable mid-hold
        hold_ack = 1'b1;
        idle(3, "R8");
        en_hold = 1'b1;
        idle(4, "R8");
        hold_ack = 1'b0;
        idle(2, "R8");

        // R7: long hold gives one pulse
        pulse_len = 4'd1;
        hold_ack = 1'b1;
        idle(30, "R7");
        hold_ack = 1'b0;
        idle(2, "R7");
        // back-to-back holds, as periodic refresh would cause
        for (int k = 0; k < 3; k++) begin
            hold_ack = 1'b1;
            idle(2, "R7");
            hold_ack = 1'b0;
            idle(3, "R7");
        end

        // R1: reset in the middle of a pulse
        pulse_len = 4'd8;
        bus(1'b0, 1'b1, 1'b0, 1'b1, "R1");
        rst_n = 1'b0;
        #1;
        n_checks++;
        if (flush_n !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: flush_n=%b expected 1 in reset", flush_n);
        end
        idle(2, "R1");
        rst_n = 1'b1;
        idle(2, "R1");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule